// File: doc/BRIEF.md
# Byte-Lane Word Memory Slave

This block is a 16-bit word-organised memory that answers bus microcycles from a master of the asynchronous, strobe-based 16-bit family. Each clock the master presents one microcycle descriptor: a seven-bit operation code, a 24-bit byte address and, for writes, a 16-bit data word. The operation code says whether the cycle moves data and, if so, whether it moves a whole word or a single byte, and in which direction. There are no separate upper and lower data strobe pins. The byte lane comes from address bit 0, and lanes are numbered in big-endian order.

A data cycle is answered one clock later. A one-clock acknowledge pulse goes out together with the registered read data. Byte reads come back right-aligned in the low half of the read bus. Byte writes merge the new lane into the stored word and leave the other lane alone. Cycles that only carry address activity get no acknowledge and do not touch storage or the read bus. The memory depth is a parameter in words, and the word index wraps modulo that depth.

Top module: `busmem_slave`

## Requirements
- R1: While reset is asserted, and after it is released with no cycle applied, `mc_dtack` is 0 and `mc_rdata` is 0x0000.
- R2: A word read (op bit 2 = 1, op bit 3 = 0, op bit 4 = 1) returns the full stored word on `mc_rdata` in the clock after the cycle is sampled.
- R3: A word write (op bit 2 = 1, op bit 3 = 0, op bit 4 = 0) replaces all 16 bits of the addressed word with `mc_wdata`.
- R4: A byte write (op bit 3 = 1, op bit 2 = 0, op bit 4 = 0) at an even address replaces bits 15:8 with `mc_wdata[15:8]`. At an odd address it replaces bits 7:0 with `mc_wdata[7:0]`. The other lane keeps its old value.
- R5: A byte read (op bit 3 = 1, op bit 2 = 0, op bit 4 = 1) returns bits 15:8 for an even address, or bits 7:0 for an odd address, in `mc_rdata[7:0]`, with `mc_rdata[15:8]` = 0.
- R6: A cycle with op bits 2 and 3 both 0 (cycle type in op[1:0]: 0 idle, 1 new address, 2 same address) raises no acknowledge, writes nothing and leaves `mc_rdata` unchanged, whatever op bit 4 and `mc_wdata` hold.
- R7: A cycle with op bits 2 and 3 both 1 is treated as no access: no acknowledge, no write, `mc_rdata` unchanged.
- R8: The word index is `mc_addr[23:1]` modulo the depth. Address bit 0 does not affect a word access, and addresses that differ only above the index width reach the same word.
- R9: Every read or write data cycle gives `mc_dtack` = 1 for exactly the following clock. Back-to-back data cycles give one pulse each, and `mc_rdata` is not disturbed by writes.
- R10: The function-code bits op[6:5] have no effect on the access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_op | input | 7 | Operation code: [1:0] cycle type, [2] word, [3] byte, [4] read, [6:5] function code |
| mc_addr | input | 24 | Byte address of the microcycle |
| mc_wdata | input | 16 | Write data, big-endian lanes |
| mc_rdata | output | 16 | Registered read data, held between reads |
| mc_dtack | output | 1 | One-clock acknowledge for each data cycle |

## Verification
The bench aims at lane selection: a byte write to the wrong lane, or a merge that clears the other lane, shows up when the word is read back, and a byte read that is not right-aligned leaves the value in the upper half. It applies address-only cycles with the read flag set, and cycles with both size flags set. A design that keyed its response on the read flag alone would acknowledge these cycles or overwrite the held read data. It also aliases addresses through bit 0 and through bits above the array's index width, which catches an index that was not shifted or not wrapped. Back-to-back data cycles are checked for one acknowledge per cycle, and for read data that does not change during writes.

// File: rtl/busmem_pkg.sv
package busmem_pkg;
  localparam int OP_W      = 7;
  localparam int ADDR_W    = 24;
  localparam int DATA_W    = 16;
  localparam int BIT_WORD  = 2;
  localparam int BIT_BYTE  = 3;
  localparam int BIT_READ  = 4;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_WORD = 2'd1,
    ACC_BYTE = 2'd2
  } acc_kind_e;

  // Word index: byte address with bit 0 dropped.
  function automatic logic [ADDR_W-2:0] f_word_index(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:1];
  endfunction

  // Right-shift that brings the addressed byte to bits 7:0 (even -> 8, odd -> 0).
  function automatic logic [3:0] f_byte_shift(input logic a0);
    return a0 ? 4'd0 : 4'd8;
  endfunction

  // Lane mask of the addressed byte (even -> upper lane).
  function automatic logic [DATA_W-1:0] f_byte_mask(input logic a0);
    return 16'hFF00 >> (a0 ? 4'd8 : 4'd0);
  endfunction
endpackage

// File: rtl/busmem_decode.sv
module busmem_decode
  import busmem_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OP_W-1:0] op,
  output acc_kind_e       kind,
  output logic            rd_fire,
  output logic            wr_fire
);
  logic word_f, byte_f, read_f;
  logic unused_fields;

  assign word_f = op[BIT_WORD];
  assign byte_f = op[BIT_BYTE];
  assign read_f = op[BIT_READ];
  // cycle type and function code do not steer the data path
  assign unused_fields = ^{op[6:5], op[1:0]};

  always_comb begin
    unique case ({byte_f, word_f})
      2'b01:   kind = ACC_WORD;
      2'b10:   kind = ACC_BYTE;
      default: kind = ACC_NONE;
    endcase
  end

  assign rd_fire = (kind != ACC_NONE) &&  read_f;
  assign wr_fire = (kind != ACC_NONE) && !read_f;

  p_both_flags_inert_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op[BIT_WORD] && op[BIT_BYTE]) |-> !(rd_fire || wr_fire));

  p_single_action_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_fire, wr_fire}));
endmodule

// File: rtl/busmem_lane.sv
module busmem_lane
  import busmem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic              is_byte,
  input  logic              a0,
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] merged,
  output logic [DATA_W-1:0] rd_value
);
  logic [DATA_W-1:0] lane_mask;
  logic [3:0]        lane_shift;

  assign lane_mask  = f_byte_mask(a0);
  assign lane_shift = f_byte_shift(a0);

  always_comb begin
    if (is_byte) begin
      merged   = (wdata & lane_mask) | (old_word & ~lane_mask);
      rd_value = (old_word >> lane_shift) & 16'h00FF;
    end else begin
      merged   = wdata;
      rd_value = old_word;
    end
  end

  p_keep_other_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && is_byte) |->
      (a0 ? (merged[15:8] == old_word[15:8]) : (merged[7:0] == old_word[7:0])));
endmodule

// File: rtl/busmem_store.sv
module busmem_store
  import busmem_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
)(
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rword
);
  logic [DATA_W-1:0] mem [DEPTH];

  assign rword = mem[idx];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end
endmodule

// File: rtl/busmem_slave.sv
module busmem_slave
  import busmem_pkg::*;
#(
  parameter int DEPTH_WORDS = 256,
  localparam int IDX_W = $clog2(DEPTH_WORDS)
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [6:0]  mc_op,
  input  logic [23:0] mc_addr,
  input  logic [15:0] mc_wdata,
  output logic [15:0] mc_rdata,
  output logic        mc_dtack
);
  acc_kind_e         kind;
  logic              rd_fire, wr_fire, acc_fire;
  logic [ADDR_W-2:0] widx_full;
  logic [IDX_W-1:0]  widx;
  logic [DATA_W-1:0] old_word, merged, rd_value;
  logic              unused_hi;

  busmem_decode u_dec (
    .clk(clk), .rst_n(rst_n), .op(mc_op),
    .kind(kind), .rd_fire(rd_fire), .wr_fire(wr_fire)
  );

  assign widx_full = f_word_index(mc_addr);
  assign widx      = widx_full[IDX_W-1:0];
  assign unused_hi = ^widx_full[ADDR_W-2:IDX_W];
  assign acc_fire  = rd_fire || wr_fire;

  busmem_store #(.DEPTH(DEPTH_WORDS)) u_store (
    .clk(clk), .we(wr_fire), .idx(widx), .wdata(merged), .rword(old_word)
  );

  busmem_lane u_lane (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire),
    .is_byte(kind == ACC_BYTE), .a0(mc_addr[0]),
    .old_word(old_word), .wdata(mc_wdata),
    .merged(merged), .rd_value(rd_value)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mc_dtack <= 1'b0;
      mc_rdata <= '0;
    end else begin
      mc_dtack <= acc_fire;
      if (rd_fire) mc_rdata <= rd_value;
    end
  end

  p_dtack_from_data_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mc_dtack |-> $past(acc_fire));

  p_rdata_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_fire) |-> $stable(mc_rdata));
endmodule

// File: tb/busmem_slave_bench.sv
`timescale 1ns/1ps
module busmem_slave_bench;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  mc_op = '0;
  logic [23:0] mc_addr = '0;
  logic [15:0] mc_wdata = '0;
  logic [15:0] mc_rdata;
  logic        mc_dtack;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [15:0] model [DEPTH];
  logic [15:0] last_rd = 16'h0000;

  logic [15:0] q_rd [$];
  logic        q_ack [$];
  string       q_tag [$];

  always #2.5 clk = ~clk;

  busmem_slave #(.DEPTH_WORDS(DEPTH)) u_busmem_slave (
    .clk(clk), .rst_n(rst_n), .mc_op(mc_op), .mc_addr(mc_addr),
    .mc_wdata(mc_wdata), .mc_rdata(mc_rdata), .mc_dtack(mc_dtack)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: present one microcycle, push its expected response.
  task automatic apply(input logic [6:0] op, input logic [23:0] a,
                       input logic [15:0] wd, input string tag);
    int i;
    bit w, b, rd;
    logic [15:0] m;
    @(negedge clk);
    mc_op = op; mc_addr = a; mc_wdata = wd;
    i  = int'(a[23:1]) % DEPTH;
    w  = op[2]; b = op[3]; rd = op[4];
    if (w && !b) begin
      if (rd) last_rd = model[i]; else model[i] = wd;
    end else if (b && !w) begin
      m = a[0] ? 16'h00FF : 16'hFF00;
      if (rd) last_rd = a[0] ? {8'h00, model[i][7:0]} : {8'h00, model[i][15:8]};
      else    model[i] = (wd & m) | (model[i] & ~m);
    end
    q_ack.push_back(w ^ b);
    q_rd.push_back(last_rd);
    q_tag.push_back(tag);
  endtask

  // Monitor: compare after each edge that consumed a queued cycle.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_tag.size() > 0) begin
        string t;
        t = q_tag.pop_front();
        check({t, " dtack"}, {15'h0, mc_dtack}, {15'h0, q_ack.pop_front()});
        check({t, " rdata"}, mc_rdata, q_rd.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset dtack", {15'h0, mc_dtack}, 16'h0);
    check("R1 reset rdata", mc_rdata, 16'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 post-reset dtack", {15'h0, mc_dtack}, 16'h0);
    check("R1 post-reset rdata", mc_rdata, 16'h0);

    apply(7'h04, 24'h000010, 16'hA5C3, "R3 word write");
    apply(7'h14, 24'h000010, 16'h0000, "R2 word read");
    apply(7'h08, 24'h000010, 16'h7E11, "R4 byte write even");
    apply(7'h08, 24'h000011, 16'h22BB, "R4 byte write odd");
    apply(7'h14, 24'h000010, 16'h0000, "R4 readback");
    apply(7'h18, 24'h000010, 16'h0000, "R5 byte read even");
    apply(7'h18, 24'h000011, 16'h0000, "R5 byte read odd");
    apply(7'h10, 24'h000010, 16'hFFFF, "R6 idle read flag");
    apply(7'h11, 24'h000010, 16'hFFFF, "R6 new-address read flag");
    apply(7'h02, 24'h000010, 16'hFFFF, "R6 same-address write");
    apply(7'h01, 24'h000010, 16'hFFFF, "R6 new-address write");
    apply(7'h14, 24'h000010, 16'h0000, "R6 storage intact");
    apply(7'h0C, 24'h000010, 16'hFFFF, "R7 both flags write");
    apply(7'h1C, 24'h000010, 16'h0000, "R7 both flags read");
    apply(7'h18, 24'h000011, 16'h0000, "R7 storage intact");
    apply(7'h04, 24'h000201, 16'h1234, "R8 write wraps");
    apply(7'h14, 24'h000000, 16'h0000, "R8 alias low word");
    apply(7'h14, 24'h000011, 16'h0000, "R8 bit0 ignored on word");
    apply(7'h14, 24'hFFFE10, 16'h0000, "R8 high bits alias");
    apply(7'h04, 24'h000020, 16'hBEEF, "R9 back-to-back write");
    apply(7'h04, 24'h000022, 16'hCAFE, "R9 back-to-back write 2");
    apply(7'h14, 24'h000020, 16'h0000, "R9 back-to-back read");
    apply(7'h08, 24'h000023, 16'h0099, "R9 write keeps rdata");
    apply(7'h00, 24'h000000, 16'h0000, "R9 dtack drops");
    apply(7'h74, 24'h000022, 16'h0000, "R10 fc=3 word read");
    apply(7'h48, 24'h000022, 16'h5500, "R10 fc=2 byte write");
    apply(7'h38, 24'h000022, 16'h0000, "R10 fc=1 byte read");
    apply(7'h14, 24'h000022, 16'h0000, "R10 readback");

    @(negedge clk);
    mc_op = '0; mc_addr = '0; mc_wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule